// File: doc/BRIEF.md
# ADC Sample Burst Streamer

This block sits between a free-running 8-bit ADC and a synchronous 32-bit FIFO-style USB bridge. It packs every four accepted samples into one 32-bit word and places the words in an on-chip elastic buffer. It drains that buffer toward the bridge only in fixed-size bursts. A burst of BURST_WORDS words (1024 words, or 4096 bytes, by default) begins only when the whole burst is already buffered. As a result, the bridge never sees a write stop part way through a burst, and the host never receives a short packet in the middle of the stream.

After reset the block sends filler words. Each filler word is a 32-bit count, which lets the host confirm that the link is delivering a continuous stream before capture starts. A one-cycle start pulse arms the switch to real samples. The switch takes effect at the next burst boundary in the buffered stream, so every burst holds only filler words or only sample words. If the downstream side stalls for so long that the buffer fills, each new word is dropped and a sticky overflow flag is raised.

The sample input has no ready signal, because the ADC cannot be paused. The output is a valid/ready stream:
- A word moves only in a cycle where both valid and ready are high.
- While ready is low, the block holds the current word and the burst pauses. It resumes at the same word and does not restart the burst.
- Once a burst has begun, valid stays high until the last word of that burst is accepted.

Samples and output share one clock. BURST_WORDS must not exceed BUF_WORDS, and BUF_WORDS must be a power of two. For deployment, use a buffer of 8192 to 16384 words (32 to 64 KB).

Top module: `adc_burst_streamer`

## Requirements
- R1: In the packed word, the first of each group of four accepted samples occupies bits [7:0], the second [15:8], the third [23:16] and the fourth [31:24]. Samples presented while smp_valid is low are ignored. The first group after reset starts with the first accepted sample.
- R2: out_valid rises only when at least BURST_WORDS words are buffered. Each burst transfers exactly BURST_WORDS words. out_last is high only on the final word of a burst, and out_valid stays high from the first word of a burst until its final word is accepted.
- R3: While out_valid is high and out_ready is low, out_data and out_last hold their values and out_valid stays high.
- R4: Before capture is live, each packed word is replaced by a filler word. The filler value starts at 0 after reset and increases by 1 for every filler word generated, including filler words that are dropped.
- R5: No sample word is emitted before a start pulse. After a start pulse, the switch to sample words happens at the first word of a burst in the buffered sequence. No burst mixes filler and sample words, and no filler burst follows a sample burst.
- R6: A packed word that arrives while the buffer holds BUF_WORDS words is dropped and sets overflow. overflow then stays high until reset, and it stays low while the buffer never fills.
- R7: While reset is low, out_valid, out_last and overflow are 0. After reset, the block returns to filler mode with the filler count at 0.
- R8: Buffered words leave in arrival order. Without overflow, consecutive sample words carry consecutive sample groups.
- R9: A start pulse while capture is already live has no effect: the stream continues with sample words only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sample and output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is present on smp_data this cycle |
| smp_data | input | SAMPLE_W (8) | ADC sample |
| start | input | 1 | One-cycle pulse that arms the switch from filler to sample data |
| out_valid | output | 1 | Output word is valid (high for the whole of a burst) |
| out_ready | input | 1 | Bridge accepts the output word this cycle |
| out_data | output | SAMPLE_W*LANES (32) | Output word |
| out_last | output | 1 | Marks the final word of a burst |
| overflow | output | 1 | Sticky flag: at least one packed word was dropped |

## Verification
A lane counter that slips shows up on the first sample word. Its low byte is then not a multiple of four, or its bytes do not rise in order, and the monitor compares every accepted word against both rules. If the buffered-slot count drifts, the mode switch lands inside a burst: a burst then carries two kinds of word, and this is seen within one burst length of the switch. A wrong buffer level or wrong pointers appear within one burst in several ways:
- out_valid rises before a full burst could have been fed in;
- a sample group repeats or is skipped;
- the filler count skips.
A burst counter that is off moves out_last away from the final beat, which is flagged on the very next burst.

// File: rtl/adc_stream_pkg.sv
package adc_stream_pkg;

  typedef enum logic [0:0] {
    MODE_FILLER = 1'b0,
    MODE_LIVE   = 1'b1
  } src_mode_e;

endpackage

// File: rtl/adc_sample_packer.sv
module adc_sample_packer #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 4,
  localparam int WORD_W  = SAMPLE_W * LANES,
  localparam int IDX_W   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                pk_valid,
  output logic [WORD_W-1:0]   pk_word
);

  logic [IDX_W-1:0]    lane_q;
  logic [SAMPLE_W-1:0] held_q [LANES-1];
  logic [WORD_W-1:0]   joined;
  logic                closing;

  assign closing = smp_valid && (lane_q == IDX_W'(LANES - 1));

  // Earlier lanes come from the holding registers; the top lane is the live sample.
  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    assign joined[g*SAMPLE_W +: SAMPLE_W] = held_q[g];
  end
  assign joined[WORD_W-1 -: SAMPLE_W] = smp_data;

  always_ff @(posedge clk) begin
    if (smp_valid) begin
      for (int i = 0; i < LANES - 1; i++) begin
        if (lane_q == IDX_W'(i)) held_q[i] <= smp_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q   <= '0;
      pk_valid <= 1'b0;
      pk_word  <= '0;
    end else begin
      pk_valid <= closing;
      if (closing) pk_word <= joined;
      if (smp_valid) lane_q <= closing ? '0 : lane_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_source_mux.sv
module adc_source_mux
  import adc_stream_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BURST_WORDS = 1024,
  localparam int SLOT_W     = $clog2(BURST_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_valid,
  input  logic [WORD_W-1:0] pk_word,
  input  logic              start,
  input  logic              buf_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              live,
  output logic              overflow
);

  src_mode_e         mode_q;
  logic              pend_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] filler_q;
  logic              ovf_q;
  logic              at_edge;
  logic              take_live;

  // slot_q is the position, inside its future burst, of the next word to be buffered
  assign at_edge   = (slot_q == '0);
  assign take_live = (mode_q == MODE_LIVE) || (pend_q && at_edge);
  assign push      = pk_valid && !buf_full;
  assign push_word = take_live ? pk_word : filler_q;
  assign live      = (mode_q == MODE_LIVE);
  assign overflow  = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_FILLER;
      pend_q   <= 1'b0;
      slot_q   <= '0;
      filler_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (start && mode_q == MODE_FILLER) pend_q <= 1'b1;
      if (pk_valid && !take_live) filler_q <= filler_q + 1'b1;
      if (push) begin
        slot_q <= (slot_q == SLOT_W'(BURST_WORDS - 1)) ? '0 : slot_q + 1'b1;
        if (pend_q && at_edge) begin
          mode_q <= MODE_LIVE;
          pend_q <= 1'b0;
        end
      end
      if (pk_valid && buf_full) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_elastic_buf.sv
module adc_elastic_buf #(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 4096,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_word,
  output logic [LVL_W-1:0] level,
  output logic             full
);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wr_q;
  logic [ADDR_W-1:0] rd_q;
  logic [LVL_W-1:0]  lvl_q;

  assign rd_word = mem[rd_q];
  assign level   = lvl_q;
  assign full    = (lvl_q == LVL_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

endmodule

// File: rtl/adc_burst_gate.sv
module adc_burst_gate #(
  parameter int BURST_WORDS = 1024,
  parameter int LVL_W       = 13,
  localparam int BEAT_W     = $clog2(BURST_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             pop
);

  logic              active_q;
  logic [BEAT_W-1:0] beat_q;

  assign out_valid = active_q;
  assign out_last  = active_q && (beat_q == BEAT_W'(BURST_WORDS - 1));
  assign pop       = active_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (!active_q) begin
      beat_q <= '0;
      if (level >= LVL_W'(BURST_WORDS)) active_q <= 1'b1;
    end else if (out_ready) begin
      if (out_last) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_burst_streamer.sv
module adc_burst_streamer #(
  parameter int SAMPLE_W    = 8,
  parameter int LANES       = 4,
  parameter int BURST_WORDS = 1024,
  parameter int BUF_WORDS   = 4096,
  localparam int WORD_W     = SAMPLE_W * LANES,
  localparam int LVL_W      = $clog2(BUF_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                start,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic                out_last,
  output logic                overflow
);

  logic              pk_valid;
  logic [WORD_W-1:0] pk_word;
  logic              buf_push;
  logic [WORD_W-1:0] buf_word;
  logic              buf_pop;
  logic [LVL_W-1:0]  buf_level;
  logic              buf_full;
  logic              src_live;

  adc_sample_packer #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .pk_valid  (pk_valid),
    .pk_word   (pk_word)
  );

  adc_source_mux #(
    .WORD_W      (WORD_W),
    .BURST_WORDS (BURST_WORDS)
  ) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .pk_valid  (pk_valid),
    .pk_word   (pk_word),
    .start     (start),
    .buf_full  (buf_full),
    .push      (buf_push),
    .push_word (buf_word),
    .live      (src_live),
    .overflow  (overflow)
  );

  adc_elastic_buf #(
    .WIDTH (WORD_W),
    .DEPTH (BUF_WORDS)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (buf_push),
    .push_word (buf_word),
    .pop       (buf_pop),
    .rd_word   (out_data),
    .level     (buf_level),
    .full      (buf_full)
  );

  adc_burst_gate #(
    .BURST_WORDS (BURST_WORDS),
    .LVL_W       (LVL_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (buf_level),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .pop       (buf_pop)
  );

endmodule

// File: rtl/adc_burst_streamer_chk.sv
module adc_burst_streamer_chk #(
  parameter int BURST_WORDS = 1024,
  parameter int BUF_WORDS   = 4096,
  parameter int WORD_W      = 32,
  parameter int LVL_W       = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last,
  input logic              overflow,
  input logic              live,
  input logic [LVL_W-1:0]  level
);

  int beats_q;

  always_ff @(posedge clk) begin
    if (!rst_n) beats_q <= 0;
    else if (out_valid && out_ready) beats_q <= out_last ? 0 : beats_q + 1;
  end

  AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid); // R2
  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> beats_q == BURST_WORDS - 1); // R2
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R2
  AST_BURST_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> int'($past(level)) >= BURST_WORDS); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R3
  AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> live); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R6
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= BUF_WORDS); // R6

endmodule

bind adc_burst_streamer adc_burst_streamer_chk #(
  .BURST_WORDS (BURST_WORDS),
  .BUF_WORDS   (BUF_WORDS),
  .WORD_W      (WORD_W),
  .LVL_W       (LVL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .overflow  (overflow),
  .live      (src_live),
  .level     (buf_level)
);

// File: tb/adc_burst_streamer_bench.sv
module adc_burst_streamer_bench;

  localparam int BW    = 8;
  localparam int DEPTH = 32;
  localparam int NSEG  = 8;

  // segment: {expect_live_seen, start, ready_mask[3:0], valid_mask[3:0], cycles[15:0]}
  localparam logic [25:0] SEG [NSEG] = '{
    {1'b0, 1'b0, 4'b1111, 4'b1111, 16'd600},
    {1'b0, 1'b0, 4'b0110, 4'b1010, 16'd400},
    {1'b0, 1'b1, 4'b1111, 4'b1111, 16'd1},
    {1'b1, 1'b0, 4'b1011, 4'b1111, 16'd800},
    {1'b1, 1'b0, 4'b0001, 4'b0111, 16'd400},
    {1'b1, 1'b1, 4'b1111, 4'b1111, 16'd1},
    {1'b1, 1'b0, 4'b1111, 4'b1101, 16'd600},
    {1'b1, 1'b0, 4'b1111, 4'b0000, 16'd300}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic        start = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;
  logic        overflow;

  always #2 clk = ~clk;

  adc_burst_streamer #(
    .SAMPLE_W    (8),
    .LANES       (4),
    .BURST_WORDS (BW),
    .BUF_WORDS   (DEPTH)
  ) u_adc_burst_streamer (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .start     (start),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .overflow  (overflow)
  );

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;

  int          beat_idx, words_out, samples_in, real_after2, dummy_after2;
  bit          burst_real, seen_real, have_b, mon_en, started, started2;
  bit          hold_pend, hold_last, prev_valid, after_rst;
  logic [31:0] exp_dummy, hold_data;
  logic [7:0]  exp_b;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mon_reset();
    beat_idx = 0; words_out = 0; samples_in = 0; real_after2 = 0; dummy_after2 = 0;
    burst_real = 0; seen_real = 0; have_b = 0; started = 0; started2 = 0;
    hold_pend = 0; hold_last = 0; prev_valid = 0; after_rst = 1;
    exp_dummy = 0; hold_data = 0; exp_b = 0;
  endtask

  task automatic observe();
    bit         is_real;
    logic [7:0] b;
    if (hold_pend)
      check(out_valid && out_data == hold_data && out_last == hold_last,
            "R3 word held under back-pressure", out_data, hold_data);
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    hold_last = out_last;
    if (out_valid && !prev_valid)
      check((samples_in / 4 - words_out) >= BW, "R2 burst began before full burst buffered",
            32'(samples_in / 4 - words_out), BW);
    if (out_valid && out_ready) begin
      is_real = (out_data[31:24] != 8'h00);
      if (beat_idx == 0) begin
        burst_real = is_real;
        if (is_real) begin
          check(started, "R5 sample word before start", 32'(is_real), 32'd0);
          seen_real = 1;
          if (started2) real_after2++;
        end else begin
          check(!seen_real, "R5 filler burst after sample burst", 32'(is_real), 32'd1);
          if (started2) dummy_after2++;
        end
      end else begin
        check(is_real == burst_real, "R5 burst mixes filler and samples", 32'(is_real), 32'(burst_real));
      end
      check(out_last == (beat_idx == BW - 1), "R2 out_last position", 32'(out_last), 32'(beat_idx == BW - 1));
      if (is_real) begin
        b = out_data[7:0];
        check(out_data == {b + 8'd3, b + 8'd2, b + 8'd1, b} && b[1:0] == 2'b00,
              "R1 little-endian packing", out_data, {b + 8'd3, b + 8'd2, b + 8'd1, b});
        if (have_b) check(b == exp_b, "R8 sample groups in order", 32'(b), 32'(exp_b));
        exp_b = b + 8'd4;
        have_b = 1;
      end else begin
        if (after_rst) check(out_data == 32'd0, "R7 filler count restarts at 0", out_data, 32'd0);
        check(out_data == exp_dummy, "R4 filler count", out_data, exp_dummy);
        exp_dummy++;
      end
      after_rst = 0;
      beat_idx = (beat_idx == BW - 1) ? 0 : beat_idx + 1;
      words_out++;
    end
    prev_valid = out_valid;
  endtask

  task automatic step(input bit v, input bit r, input bit st);
    @(negedge clk);
    smp_valid = v;
    smp_data  = v ? samples_in[7:0] : 8'h5A;
    if (v) samples_in++;
    out_ready = r;
    start     = st;
    if (st) begin
      if (started) started2 = 1;
      started = 1;
    end
    #1;
    if (mon_en) observe();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected<%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mon_reset();
    mon_en = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    check(!out_valid && !out_last && !overflow, "R7 outputs idle in reset",
          {29'd0, out_valid, out_last, overflow}, 32'd0);
    rst_n = 1'b1;
    mon_en = 1;

    // table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < int'(SEG[s][15:0]); c++)
        step(SEG[s][16 + (c % 4)], SEG[s][20 + (c % 4)], SEG[s][24]);
      check(seen_real == SEG[s][25], "R5 capture state after segment", 32'(seen_real), 32'(SEG[s][25]));
      check(!overflow, "R6 no overflow without a full buffer", 32'(overflow), 32'd0);
    end
    check(real_after2 > 0 && dummy_after2 == 0, "R9 repeated start leaves stream live",
          32'(dummy_after2), 32'd0);
    check(beat_idx == 0, "R2 stream ends on burst boundary", 32'(beat_idx), 32'd0);

    // overflow: stall downstream until the buffer fills
    mon_en = 0;
    for (int i = 0; i < 4 * (DEPTH + BW) + 16; i++) step(1'b1, 1'b0, 1'b0);
    check(overflow, "R6 overflow after buffer fills", 32'(overflow), 32'd1);
    check(out_valid, "R3 burst waits under stall", 32'(out_valid), 32'd1);
    for (int i = 0; i < 120; i++) step(1'b0, 1'b1, 1'b0);
    check(overflow, "R6 overflow sticky after drain", 32'(overflow), 32'd1);

    // reset mid-run
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0);
    check(!out_valid && !out_last && !overflow, "R7 reset clears outputs",
          {29'd0, out_valid, out_last, overflow}, 32'd0);
    step(1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    mon_reset();
    mon_en = 1;
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b0, 1'b1, 1'b0);
    check(words_out >= BW && !seen_real, "R7 filler bursts resume after reset", 32'(words_out), BW);
    check(!overflow, "R7 overflow stays clear after reset", 32'(overflow), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule